// File: doc/BRIEF.md
# Protection Entry CSR Bank

This block stores the settings of a parameterised set of physical-memory-protection entries (16 by default): one configuration byte and one address register for each entry, plus a small security register. A single request port carries a valid strobe, a write enable, a two-bit target select and an index. Through this port, software-style accesses read and write packed configuration words, individual address registers and the security register. Read data is returned combinationally from the current request.

Every write passes through lock rules before it reaches storage. A write that the rules reject is dropped without any indication. The rules depend on three things: each entry's lock bit, the lock bit and match mode of the next entry up, and the state of the security register. The security register has two sticky bits and one bypass bit whose setting is guarded. Any configuration write, accepted or not, raises a one-cycle flush pulse so that cached permissions can be discarded downstream. The stored configuration bytes, address registers and security bits are exported unchanged for a separate range decoder and permission checker.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, every configuration byte, address register and security bit is zero, and the flush output is low.
- R2: A configuration word at index n packs one byte per entry, with XLEN/8 bytes per word. Bits 8i+7:8i belong to entry n*(XLEN/8)+i. Within a byte, bit0 is read, bit1 is write, bit2 is execute, bits 4:3 are the match mode (01 is top-of-range) and bit7 is the lock. Reading a word returns the stored bytes in this layout.
- R3: When the enhanced mode input is low, a configuration byte whose stored lock bit is set keeps its value on a write. The other bytes of the same word are still stored.
- R4: When the enhanced mode input is high, a byte is stored if the bypass bit is set, or if the lockdown bit is clear and the entry's stored lock bit is clear.
- R5: When the enhanced mode input is high and lockdown is set, a byte is also stored if the new byte has lock=1 and execute=0, or if it has lock=0 and its bits 2:0 are not exactly 3'b110. This holds even when the entry is already locked.
- R6: A write to an address register is dropped if that entry is locked. It is also dropped if the next entry is locked and in top-of-range mode. The last entry has no next entry.
- R7: A configuration word index whose entries all lie beyond the implemented count, or an address index at or above the entry count, ignores writes and reads back zero.
- R8: The security register holds lockdown at bit0, whitelist at bit1 and bypass at bit2. Once lockdown or whitelist is set, a write cannot clear it.
- R9: The bypass bit cannot go from 0 to 1 while any entry's lock bit is set. In all other cases it follows the written value.
- R10: Every write request with select 0 (configuration), whether in range or not and whether accepted or not, makes the flush output high for exactly the next cycle. Without such a request, flush is low.
- R11: The exported configuration, address and security outputs always equal the stored state.
- R12: Select codes: 0 configuration, 1 address, 2 security, 3 unused. Select 3 reads zero and its writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enhanced_i | input | 1 | Selects the enhanced lock rules |
| req_valid | input | 1 | Request strobe |
| req_we | input | 1 | Write enable for the request |
| req_sel | input | 2 | Target select (0 cfg, 1 addr, 2 security, 3 none) |
| req_idx | input | IDX_W | Word or entry index |
| req_wdata | input | XLEN | Write data |
| rsp_rdata | output | XLEN | Read data for the current request |
| flush_o | output | 1 | One-cycle pulse after a configuration write |
| cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7:8e |
| addr_o | output | NUM_ENTRIES*XLEN | All address registers, entry e at slice e |
| sec_o | output | 3 | Security bits {bypass, whitelist, lockdown} |

## Verification
The bench targets several corner cases. A locked entry shares a packed word with unlocked neighbours; a design that gated the whole word would freeze the neighbours, and one that ignored the byte lock would overwrite the locked entry. An address write sits just below a locked top-of-range entry, and also below a locked entry in another mode; a design that got the neighbour check wrong would either let the lower bound move or block writes it should accept. Under lockdown, the bench writes byte patterns that fall on both sides of the lock/execute and write-plus-execute exceptions, including rewrites of already locked entries. Security writes try to clear the sticky bits and to raise bypass while entries are locked; a faulty design would show these bits changing. Out-of-range indices, the unused select code and attempted configuration writes that are rejected check that storage stays put while flush still pulses.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

    // Target select codes on the request port
    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_SEC  = 2'd2,
        SEL_NONE = 2'd3
    } bank_sel_e;

    // Bit positions inside one configuration byte
    localparam int unsigned CB_R    = 0;
    localparam int unsigned CB_W    = 1;
    localparam int unsigned CB_X    = 2;
    localparam int unsigned CB_A_LO = 3;
    localparam int unsigned CB_A_HI = 4;
    localparam int unsigned CB_L    = 7;

    localparam logic [1:0] MODE_TOR = 2'b01;

    // Security register, bit2 bypass, bit1 whitelist, bit0 lockdown
    typedef struct packed {
        logic bypass;
        logic whitelist;
        logic lockdown;
    } sec_bits_t;

endpackage

// File: rtl/pmp_cfg_gate.sv
module pmp_cfg_gate
    import pmp_bank_pkg::*;
(
    input  logic       enhanced_i,
    input  logic       lockdown_i,
    input  logic       bypass_i,
    input  logic       old_lock_i,
    input  logic       new_lock_i,
    input  logic [2:0] new_rwx_i,
    output logic       accept_o
);

    logic legacy_ok;
    logic relaxed_ok;
    logic lockdown_ok;

    always_comb begin
        legacy_ok   = !old_lock_i;
        relaxed_ok  = !lockdown_i && !old_lock_i;
        lockdown_ok = lockdown_i &&
                      ((new_lock_i && !new_rwx_i[CB_X]) ||
                       (!new_lock_i && (new_rwx_i != 3'b110)));
        if (enhanced_i) begin
            accept_o = bypass_i || relaxed_ok || lockdown_ok;
        end else begin
            accept_o = legacy_ok;
        end
    end

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
    import pmp_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  sec_bits_t wdata_i,
    input  logic      any_locked_i,
    output sec_bits_t sec_o
);

    sec_bits_t sec_d;
    sec_bits_t sec_q;

    always_comb begin
        sec_d = sec_q;
        if (wr_i) begin
            sec_d = wdata_i;
            if (!sec_q.bypass && any_locked_i) begin
                sec_d.bypass = 1'b0;
            end
            sec_d.lockdown  = wdata_i.lockdown  | sec_q.lockdown;
            sec_d.whitelist = wdata_i.whitelist | sec_q.whitelist;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign sec_o = sec_q;

    a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q.lockdown |=> sec_q.lockdown);

    a_r8_whitelist_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q.whitelist |=> sec_q.whitelist);

    a_r9_bypass_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_q.bypass && any_locked_i) |=> !sec_q.bypass);

endmodule

// File: rtl/pmp_rd_mux.sv
module pmp_rd_mux
    import pmp_bank_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned XLEN        = 32,
    parameter int unsigned IDX_W       = 6
) (
    input  logic [1:0]                       sel_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [NUM_ENTRIES-1:0][7:0]      cfg_i,
    input  logic [NUM_ENTRIES-1:0][XLEN-1:0] addr_i,
    input  sec_bits_t                        sec_i,
    output logic [XLEN-1:0]                  rdata_o
);

    localparam int unsigned BPC = XLEN / 8;

    logic [31:0] base_ent;

    always_comb begin
        rdata_o  = '0;
        base_ent = 32'(idx_i) * BPC;
        case (bank_sel_e'(sel_i))
            SEL_CFG: begin
                for (int unsigned e = 0; e < NUM_ENTRIES; e++) begin
                    if ((e >= base_ent) && (e < base_ent + BPC)) begin
                        rdata_o[8*(e%BPC) +: 8] = cfg_i[e];
                    end
                end
            end
            SEL_ADDR: begin
                for (int unsigned e = 0; e < NUM_ENTRIES; e++) begin
                    if (32'(idx_i) == e) begin
                        rdata_o = addr_i[e];
                    end
                end
            end
            SEL_SEC: begin
                rdata_o[2:0] = sec_i;
            end
            default: begin
                rdata_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_bank_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned XLEN        = 32,
    parameter int unsigned IDX_W       = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enhanced_i,
    input  logic                          req_valid,
    input  logic                          req_we,
    input  logic [1:0]                    req_sel,
    input  logic [IDX_W-1:0]              req_idx,
    input  logic [XLEN-1:0]               req_wdata,
    output logic [XLEN-1:0]               rsp_rdata,
    output logic                          flush_o,
    output logic [NUM_ENTRIES*8-1:0]      cfg_o,
    output logic [NUM_ENTRIES*XLEN-1:0]   addr_o,
    output logic [2:0]                    sec_o
);

    localparam int unsigned BPC = XLEN / 8;

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][7:0]      cfg;
        logic [NUM_ENTRIES-1:0][XLEN-1:0] addr;
        logic                             flush;
    } bank_state_t;

    bank_state_t state_d;
    bank_state_t state_q;

    logic                        wr_cfg;
    logic                        wr_addr;
    logic                        wr_sec;
    logic                        any_locked;
    sec_bits_t                   sec_q;
    logic [NUM_ENTRIES-1:0][7:0] new_byte;
    logic [NUM_ENTRIES-1:0]      cfg_hit;
    logic [NUM_ENTRIES-1:0]      addr_hit;
    logic [NUM_ENTRIES-1:0]      cfg_accept;
    logic [NUM_ENTRIES-1:0]      tor_guard;

    assign wr_cfg  = req_valid && req_we && (bank_sel_e'(req_sel) == SEL_CFG);
    assign wr_addr = req_valid && req_we && (bank_sel_e'(req_sel) == SEL_ADDR);
    assign wr_sec  = req_valid && req_we && (bank_sel_e'(req_sel) == SEL_SEC);

    // Per-entry lane decode and lock evaluation
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        localparam int unsigned LANE  = g % BPC;
        localparam int unsigned CSR_N = g / BPC;

        assign new_byte[g] = req_wdata[8*LANE +: 8];
        assign cfg_hit[g]  = (32'(req_idx) == CSR_N);
        assign addr_hit[g] = (32'(req_idx) == g);

        if (g + 1 < NUM_ENTRIES) begin : g_next
            assign tor_guard[g] = state_q.cfg[g+1][CB_L] &&
                                  (state_q.cfg[g+1][CB_A_HI:CB_A_LO] == MODE_TOR);
        end else begin : g_last
            assign tor_guard[g] = 1'b0;
        end

        pmp_cfg_gate u_gate (
            .enhanced_i (enhanced_i),
            .lockdown_i (sec_q.lockdown),
            .bypass_i   (sec_q.bypass),
            .old_lock_i (state_q.cfg[g][CB_L]),
            .new_lock_i (new_byte[g][CB_L]),
            .new_rwx_i  (new_byte[g][CB_X:CB_R]),
            .accept_o   (cfg_accept[g])
        );

        a_r3_locked_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (!enhanced_i && state_q.cfg[g][CB_L]) |=> $stable(state_q.cfg[g]));

        a_r6_locked_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.cfg[g][CB_L] |=> $stable(state_q.addr[g]));

        a_r6_tor_neighbour_guard: assert property (@(posedge clk) disable iff (!rst_n)
            tor_guard[g] |=> $stable(state_q.addr[g]));
    end

    always_comb begin
        any_locked = 1'b0;
        for (int unsigned e = 0; e < NUM_ENTRIES; e++) begin
            any_locked = any_locked | state_q.cfg[e][CB_L];
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.flush = wr_cfg;
        for (int unsigned e = 0; e < NUM_ENTRIES; e++) begin
            if (wr_cfg && cfg_hit[e] && cfg_accept[e]) begin
                state_d.cfg[e] = new_byte[e];
            end
            if (wr_addr && addr_hit[e] && !state_q.cfg[e][CB_L] && !tor_guard[e]) begin
                state_d.addr[e] = req_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    pmp_sec_reg u_sec (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_sec),
        .wdata_i      (sec_bits_t'(req_wdata[2:0])),
        .any_locked_i (any_locked),
        .sec_o        (sec_q)
    );

    pmp_rd_mux #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .XLEN        (XLEN),
        .IDX_W       (IDX_W)
    ) u_rd (
        .sel_i   (req_sel),
        .idx_i   (req_idx),
        .cfg_i   (state_q.cfg),
        .addr_i  (state_q.addr),
        .sec_i   (sec_q),
        .rdata_o (rsp_rdata)
    );

    assign flush_o = state_q.flush;
    assign cfg_o   = state_q.cfg;
    assign addr_o  = state_q.addr;
    assign sec_o   = sec_q;

    a_r10_flush_follows_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && (req_sel == 2'd0)) |=> flush_o);

    a_r10_flush_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_we && (req_sel == 2'd0)) |=> !flush_o);

    a_r7_oor_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_sel == 2'd1) && (32'(req_idx) >= NUM_ENTRIES)) |-> (rsp_rdata == '0));

    a_r12_unused_sel_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sel == 2'd3) |-> (rsp_rdata == '0));

endmodule

// File: tb/sim_pmp_csr_bank.sv
module sim_pmp_csr_bank;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 16;
    localparam int XL = 32;
    localparam int IW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enhanced = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_we = 1'b0;
    logic [1:0]      req_sel = 2'd0;
    logic [IW-1:0]   req_idx = '0;
    logic [XL-1:0]   req_wdata = '0;
    logic [XL-1:0]   rsp_rdata;
    logic            flush_o;
    logic [N*8-1:0]  cfg_o;
    logic [N*XL-1:0] addr_o;
    logic [2:0]      sec_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [7:0]  m_cfg [N];
    logic [31:0] m_addr[N];
    logic [2:0]  m_sec;

    always #10 clk = ~clk;

    pmp_csr_bank #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .enhanced_i(enhanced), .req_valid(req_valid),
        .req_we(req_we), .req_sel(req_sel), .req_idx(req_idx), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .flush_o(flush_o), .cfg_o(cfg_o), .addr_o(addr_o),
        .sec_o(sec_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_cfg_ok(bit enh, logic [2:0] sec, logic [7:0] oldb,
                                      logic [7:0] newb);
        if (!enh) return !oldb[7];
        if (sec[2]) return 1'b1;
        if (!sec[0] && !oldb[7]) return 1'b1;
        if (sec[0]) begin
            if (newb[7] && !newb[2]) return 1'b1;
            if (!newb[7] && newb[2:0] != 3'b110) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_read(int sel, int idx);
        logic [31:0] v = '0;
        case (sel)
            0: for (int b = 0; b < 4; b++) if (idx*4 + b < N) v[8*b +: 8] = m_cfg[idx*4 + b];
            1: if (idx < N) v = m_addr[idx];
            2: v = {29'd0, m_sec};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic model_apply(input int sel, input int idx, input logic [31:0] data);
        bit anyl = 1'b0;
        logic [2:0] nv;
        case (sel)
            0: for (int b = 0; b < 4; b++) begin
                int e = idx*4 + b;
                if (e < N && exp_cfg_ok(enhanced, m_sec, m_cfg[e], data[8*b +: 8]))
                    m_cfg[e] = data[8*b +: 8];
            end
            1: if (idx < N) begin
                bit blk = m_cfg[idx][7];
                if (idx + 1 < N && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'b01) blk = 1'b1;
                if (!blk) m_addr[idx] = data;
            end
            2: begin
                for (int e = 0; e < N; e++) if (m_cfg[e][7]) anyl = 1'b1;
                nv = data[2:0];
                if (!m_sec[2] && anyl) nv[2] = 1'b0;
                nv[1:0] = nv[1:0] | m_sec[1:0];
                m_sec = nv;
            end
            default: ;
        endcase
    endtask

    task automatic model_clear();
        for (int e = 0; e < N; e++) begin
            m_cfg[e] = '0;
            m_addr[e] = '0;
        end
        m_sec = '0;
    endtask

    // Starts and ends at a falling edge
    task automatic wr(input int sel, input int idx, input logic [31:0] data);
        req_valid = 1'b1; req_we = 1'b1;
        req_sel = sel[1:0]; req_idx = idx[IW-1:0]; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        model_apply(sel, idx, data);
        chk("R10", 64'(flush_o), 64'(sel == 0), "flush after write");
    endtask

    task automatic rd(input int sel, input int idx, input string req);
        req_valid = 1'b1; req_we = 1'b0;
        req_sel = sel[1:0]; req_idx = idx[IW-1:0];
        #1;
        chk(req, 64'(rsp_rdata), 64'(exp_read(sel, idx)), "read data");
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", 64'(flush_o), 64'd0, "flush low after read cycle");
    endtask

    task automatic chk_exports(input string req);
        int bad = 0;
        for (int e = 0; e < N; e++) begin
            if (cfg_o[8*e +: 8] !== m_cfg[e]) bad++;
            if (addr_o[32*e +: 32] !== m_addr[e]) bad++;
        end
        if (sec_o !== m_sec) bad++;
        chk(req, 64'(bad), 64'd0, "exported state mismatches");
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 64'(flush_o), 64'd0, "flush after reset");
        chk_exports("R1");
        rd(0, 0, "R1");
        rd(1, 3, "R1");
        rd(2, 0, "R1");
    endtask

    task automatic random_ops(input int count);
        for (int k = 0; k < count; k++) begin
            int r = int'($urandom % 10);
            int sel = (r < 4) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
            int idx;
            logic [31:0] d = $urandom;
            if (sel == 0) begin
                idx = int'($urandom % 6);
                for (int b = 0; b < 4; b++) if ($urandom % 6 != 0) d[8*b + 7] = 1'b0;
            end else if (sel == 1) begin
                idx = int'($urandom % 18);
            end else begin
                idx = int'($urandom % 4);
                if ($urandom % 8 != 0) d[1:0] = 2'b00;
            end
            wr(sel, idx, d);
            r = int'($urandom % 4);
            rd(r, (r == 0) ? int'($urandom % 6) : int'($urandom % 18), "R2 R7 R11");
            chk_exports("R11");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 64'(flush_o), 64'd0, "flush out of reset");
        chk_exports("R1");
        rd(0, 1, "R1");

        // Packing and byte layout
        wr(0, 0, 32'h0F0B0301);
        rd(0, 0, "R2");
        chk("R2", 64'(cfg_o[23:16]), 64'h0B, "entry 2 lane");
        wr(0, 1, 32'h44332211);
        chk("R2", 64'(cfg_o[39:32]), 64'h11, "entry 4 lane");

        // Legacy lock per byte
        wr(0, 0, 32'h0F8B0301);
        wr(0, 0, 32'h01020304);
        chk("R3", 64'(cfg_o[23:16]), 64'h8B, "locked byte kept");
        chk("R3", 64'(cfg_o[7:0]), 64'h04, "unlocked neighbour written");
        rd(0, 0, "R3");

        // Address gating
        wr(1, 2, 32'hAAAA0000);
        chk("R6", 64'(addr_o[95:64]), 64'd0, "own lock blocks address");
        wr(1, 1, 32'hBBBB0000);
        chk("R6", 64'(addr_o[63:32]), 64'd0, "locked TOR neighbour blocks address");
        wr(1, 3, 32'h00001234);
        chk("R6", 64'(addr_o[127:96]), 64'h1234, "free entry address stored");
        wr(0, 1, 32'h44982211);
        wr(1, 5, 32'h00000055);
        chk("R6", 64'(addr_o[191:160]), 64'h55, "locked non-TOR neighbour does not block");
        wr(1, 15, 32'h0000FFFF);
        chk("R6", 64'(addr_o[511:480]), 64'hFFFF, "last entry has no neighbour");
        rd(1, 15, "R6");

        // Out of range and unused select
        wr(0, 4, 32'hFFFFFFFF);
        rd(0, 4, "R7");
        wr(1, 16, 32'h00000001);
        rd(1, 16, "R7");
        chk_exports("R7");
        wr(3, 0, 32'hFFFFFFFF);
        rd(3, 0, "R12");
        chk_exports("R12");

        // Security register with a lock present
        wr(2, 0, 32'h7);
        chk("R9", 64'(sec_o), 64'b011, "bypass blocked by lock");
        wr(2, 0, 32'h0);
        chk("R8", 64'(sec_o), 64'b011, "sticky bits kept");
        rd(2, 0, "R8");

        // Enhanced rules
        reset_dut();
        enhanced = 1'b1;
        wr(2, 0, 32'h4);
        chk("R9", 64'(sec_o), 64'b100, "bypass set with no locks");
        wr(0, 0, 32'h00000080);
        wr(0, 0, 32'h00000001);
        chk("R4", 64'(cfg_o[7:0]), 64'h01, "bypass overrides lock");
        wr(0, 0, 32'h00000080);
        wr(2, 0, 32'h0);
        chk("R9", 64'(sec_o), 64'b000, "bypass cleared");
        wr(0, 0, 32'h00000003);
        chk("R4", 64'(cfg_o[7:0]), 64'h80, "locked entry kept without bypass");
        wr(2, 0, 32'h4);
        chk("R9", 64'(sec_o), 64'b000, "bypass cannot rise with lock");
        wr(2, 0, 32'h1);
        wr(0, 0, 32'h07068481);
        chk("R5", 64'(cfg_o[31:0]), 64'h07000081, "lockdown exceptions");
        rd(0, 0, "R5");
        chk_exports("R5");

        // Random phases
        reset_dut();
        enhanced = 1'b0;
        random_ops(700);
        reset_dut();
        enhanced = 1'b1;
        random_ops(700);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule